// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder

This block adds K unsigned words of N bits each and returns their exact total on a result bus of N + ceil(log2 K) bits. The words arrive side by side on one packed input bus. Operand 0 sits in the lowest N bits, operand 1 in the next N bits, and so on. The block is purely combinational. A new total is available at the output as soon as the operand bus settles, with no clock and no handshake.

Internally the words pass through a linear chain of K-2 carry-save stages. Each stage is a row of independent full adders. It folds one more operand into a running pair of vectors: a sum vector, and a carry vector moved up by one bit position. No carry ripples inside a stage, so every stage costs one full-adder delay. A single ripple carry-propagate adder at the end of the chain collapses the last sum/carry pair into the binary total. With K = 2 there is no carry-save stage, and the two words go straight into the final adder.

Top module: `mosum_top`

## Requirements
- R1: `sum_o` equals the exact arithmetic sum of the K operands. Operand j is taken from `ops_i[j*N +: N]`, and `sum_o` is N + ceil(log2 K) bits wide.
- R2: With K=4 and N=4, the operands 0001, 0111, 1101, 0010 (operand 0 first) give `sum_o` = 010111 (decimal 23).
- R3: Every carry-save stage keeps value. Its sum vector plus its left-shifted carry vector equals the sum of its three input vectors.
- R4: When every operand is at its maximum value 2^N-1, `sum_o` equals K*(2^N-1) and no bit is lost.
- R5: When every operand is zero, `sum_o` is zero.
- R6: With K=2 the block reduces to a single adder, and it still returns the exact sum of both operands.
- R7: The total does not depend on the order of the operands. A rotated operand order gives the same `sum_o`.
- R8: A wider configuration (K=7, N=8) returns exact totals up to 7*255 = 1785 on its 11-bit result.
- R9: The result path is combinational. `sum_o` follows a change on `ops_i` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | K*N | K packed unsigned operands; operand j at bits [j*N +: N] |
| sum_o | output | N+$clog2(K) | Exact unsigned total of all operands |

## Verification
Every result of this block is due in the same cycle as its stimulus: zero clock cycles pass between a new operand set and the matching total. The checks therefore drive the operand bus one nanosecond after a rising edge and sample the result two nanoseconds later. Both moments fall before the next falling edge, so no clock edge lies between stimulus and sample. This also shows that no register sits on the path. The stage-level value property is checked continuously on the internal carry-save vectors, while the port checks cover the exhaustive small sweep, the degenerate two-operand case and the wide random case.

// File: rtl/mosum_pkg.sv
package mosum_pkg;

    // Width of an exact total of k unsigned n-bit words.
    function automatic int total_w(input int k, input int n);
        return n + $clog2(k);
    endfunction

    // Number of carry-save stages; at least one slot so arrays stay legal.
    function automatic int stage_cnt(input int k);
        return (k > 2) ? k - 2 : 1;
    endfunction

endpackage

// File: rtl/fa_row.sv
module fa_row #(
    parameter int W  = 6,
    parameter int CW = 5
) (
    input  logic [W-1:0]  x_i,
    input  logic [W-1:0]  y_i,
    input  logic [W-1:0]  z_i,
    output logic [W-1:0]  s_o,
    output logic [CW-1:0] co_o
);
    // One full adder per column; only the low CW columns need a carry,
    // since a carry out of the top column would fall off the result.
    for (genvar b = 0; b < W; b++) begin : g_col
        assign s_o[b] = x_i[b] ^ y_i[b] ^ z_i[b];
        if (b < CW) begin : g_cy
            assign co_o[b] = (x_i[b] & y_i[b]) | (x_i[b] & z_i[b]) | (y_i[b] & z_i[b]);
        end
    end
endmodule

// File: rtl/csa_stage.sv
module csa_stage #(
    parameter int W = 6
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);
    logic [W-2:0] co_d;

    fa_row #(.W(W), .CW(W-1)) u_row (
        .x_i (x_i),
        .y_i (y_i),
        .z_i (z_i),
        .s_o (s_o),
        .co_o(co_d)
    );

    // Carries weigh twice their column: move them up one position.
    assign c_o = {co_d, 1'b0};
endmodule

// File: rtl/rc_adder.sv
module rc_adder #(
    parameter int W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] cy_d;

    assign cy_d[0] = 1'b0;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign sum_o[b] = a_i[b] ^ b_i[b] ^ cy_d[b];
        if (b < W - 1) begin : g_next
            assign cy_d[b+1] = (a_i[b] & b_i[b]) | (a_i[b] & cy_d[b]) | (b_i[b] & cy_d[b]);
        end
    end
endmodule

// File: rtl/mosum_top.sv
module mosum_top #(
    parameter int K = 4,
    parameter int N = 4,
    localparam int OUT_W = mosum_pkg::total_w(K, N)
) (
    input  logic [K*N-1:0]   ops_i,
    output logic [OUT_W-1:0] sum_o
);
    localparam int NST = mosum_pkg::stage_cnt(K);

    // Operands zero-extended to the result width.
    logic [OUT_W-1:0] opw_d [K];

    for (genvar j = 0; j < K; j++) begin : g_opnd
        assign opw_d[j] = OUT_W'(ops_i[j*N +: N]);
    end

    // Flat copies of each stage's vectors, for observation only.
    logic [NST*OUT_W-1:0] st_x;
    logic [NST*OUT_W-1:0] st_y;
    logic [NST*OUT_W-1:0] st_z;
    logic [NST*OUT_W-1:0] st_s;
    logic [NST*OUT_W-1:0] st_c;

    logic [OUT_W-1:0] cpa_a_d;
    logic [OUT_W-1:0] cpa_b_d;

    if (K == 2) begin : g_pair
        assign st_x    = '0;
        assign st_y    = '0;
        assign st_z    = '0;
        assign st_s    = '0;
        assign st_c    = '0;
        assign cpa_a_d = opw_d[0];
        assign cpa_b_d = opw_d[1];
    end else begin : g_chain
        for (genvar i = 0; i < NST; i++) begin : g_stage
            logic [OUT_W-1:0] x_d;
            logic [OUT_W-1:0] y_d;
            logic [OUT_W-1:0] z_d;
            logic [OUT_W-1:0] s_d;
            logic [OUT_W-1:0] c_d;

            if (i == 0) begin : g_first
                assign x_d = opw_d[0];
                assign y_d = opw_d[1];
            end else begin : g_next
                assign x_d = g_stage[i-1].s_d;
                assign y_d = g_stage[i-1].c_d;
            end
            assign z_d = opw_d[i+2];

            csa_stage #(.W(OUT_W)) u_csa (
                .x_i(x_d),
                .y_i(y_d),
                .z_i(z_d),
                .s_o(s_d),
                .c_o(c_d)
            );

            assign st_x[i*OUT_W +: OUT_W] = x_d;
            assign st_y[i*OUT_W +: OUT_W] = y_d;
            assign st_z[i*OUT_W +: OUT_W] = z_d;
            assign st_s[i*OUT_W +: OUT_W] = s_d;
            assign st_c[i*OUT_W +: OUT_W] = c_d;
        end
        assign cpa_a_d = g_stage[NST-1].s_d;
        assign cpa_b_d = g_stage[NST-1].c_d;
    end

    rc_adder #(.W(OUT_W)) u_cpa (
        .a_i  (cpa_a_d),
        .b_i  (cpa_b_d),
        .sum_o(sum_o)
    );
endmodule

// File: rtl/mosum_chk.sv
module mosum_chk #(
    parameter int K     = 4,
    parameter int N     = 4,
    parameter int OUT_W = 6,
    parameter int NST   = 2
) (
    input logic [K*N-1:0]     ops_i,
    input logic [OUT_W-1:0]   sum_o,
    input logic [NST*OUT_W-1:0] st_x,
    input logic [NST*OUT_W-1:0] st_y,
    input logic [NST*OUT_W-1:0] st_z,
    input logic [NST*OUT_W-1:0] st_s,
    input logic [NST*OUT_W-1:0] st_c
);
    localparam int MAX_TOT = K * ((1 << N) - 1);

    logic [OUT_W:0] ref_sum;

    always_comb begin
        ref_sum = '0;
        for (int j = 0; j < K; j++) begin
            ref_sum = ref_sum + (OUT_W+1)'(ops_i[j*N +: N]);
        end
    end

    always_comb begin
        // R1
        total_match_chk: assert ({1'b0, sum_o} == ref_sum);
        // R4
        bound_chk: assert (int'(sum_o) <= MAX_TOT);
        // R5
        zero_in_chk: assert (ops_i != '0 || sum_o == '0);
    end

    if (K > 2) begin : g_stage_chk
        for (genvar i = 0; i < NST; i++) begin : g_st
            logic [OUT_W+1:0] in_tot;
            logic [OUT_W+1:0] out_tot;
            always_comb begin
                in_tot  = (OUT_W+2)'(st_x[i*OUT_W +: OUT_W]) + (OUT_W+2)'(st_y[i*OUT_W +: OUT_W])
                        + (OUT_W+2)'(st_z[i*OUT_W +: OUT_W]);
                out_tot = (OUT_W+2)'(st_s[i*OUT_W +: OUT_W]) + (OUT_W+2)'(st_c[i*OUT_W +: OUT_W]);
                // R3
                stage_keep_chk: assert (in_tot == out_tot);
            end
        end
    end
endmodule

bind mosum_top mosum_chk #(
    .K(K), .N(N), .OUT_W(OUT_W), .NST(NST)
) chk_i (
    .ops_i(ops_i),
    .sum_o(sum_o),
    .st_x (st_x),
    .st_y (st_y),
    .st_z (st_z),
    .st_s (st_s),
    .st_c (st_c)
);

// File: tb/mosum_top_tb_top.sv
module mosum_top_tb_top;
    localparam int K0 = 4, N0 = 4, W0 = 6;
    localparam int K2 = 2, N2 = 5, W2 = 6;
    localparam int KW = 7, NW = 8, WW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [K0*N0-1:0] ops0 = '0;
    logic [W0-1:0]    sum0;
    logic [K2*N2-1:0] ops2 = '0;
    logic [W2-1:0]    sum2;
    logic [KW*NW-1:0] opsw = '0;
    logic [WW-1:0]    sumw;

    mosum_top #(.K(K0), .N(N0)) dut_i    (.ops_i(ops0), .sum_o(sum0));
    mosum_top #(.K(K2), .N(N2)) dut_k2_i (.ops_i(ops2), .sum_o(sum2));
    mosum_top #(.K(KW), .N(NW)) dut_w_i  (.ops_i(opsw), .sum_o(sumw));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Stimulus lands 1 ns after a rising edge; the sample follows 2 ns later.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R5: zero operands right after reset
        step(); #2;
        chk("R5 zero K4", int'(sum0), 0);
        chk("R5 zero K2", int'(sum2), 0);
        chk("R5 zero K7", int'(sumw), 0);

        // R2: worked example
        step(); ops0 = {4'b0010, 4'b1101, 4'b0111, 4'b0001}; #2;
        chk("R2 example", int'(sum0), 23);

        // R4: all operands at maximum
        step();
        ops0 = '1; ops2 = '1; opsw = '1;
        #2;
        chk("R4 max K4", int'(sum0), 4 * 15);
        chk("R4 max K2", int'(sum2), 2 * 31);
        chk("R4 max K7", int'(sumw), 7 * 255);

        // R9: change inputs between edges, no clock edge before sampling
        @(negedge clk); #1;
        ops0 = {4'd3, 4'd9, 4'd1, 4'd14};
        #1;
        chk("R9 no-edge update", int'(sum0), 27);

        // R1 and R3: exhaustive sweep over the K=4, N=4 configuration
        for (int v = 0; v < (1 << 16); v++) begin
            int e;
            step();
            ops0 = 16'(v);
            e = (v & 15) + ((v >> 4) & 15) + ((v >> 8) & 15) + ((v >> 12) & 15);
            #2;
            chk("R1/R3 exhaustive", int'(sum0), e);
        end

        // R6: exhaustive sweep of the two-operand configuration
        for (int v = 0; v < (1 << 10); v++) begin
            step();
            ops2 = 10'(v);
            #2;
            chk("R6 pair", int'(sum2), (v & 31) + ((v >> 5) & 31));
        end

        // R7: rotated operand order gives the same total
        for (int t = 0; t < 200; t++) begin
            logic [15:0] r;
            int first;
            r = 16'($urandom());
            step(); ops0 = r; #2;
            first = int'(sum0);
            step(); ops0 = {r[11:0], r[15:12]}; #2;
            chk("R7 rotate", int'(sum0), first);
        end

        // R8: wide configuration with random operands
        for (int t = 0; t < 3000; t++) begin
            int e;
            logic [KW*NW-1:0] p;
            e = 0;
            for (int j = 0; j < KW; j++) begin
                logic [7:0] w;
                w = 8'($urandom());
                p[j*NW +: NW] = w;
                e += int'(w);
            end
            step(); opsw = p; #2;
            chk("R8 wide", int'(sumw), e);
        end

        finish_run();
    end
endmodule